// File: doc/BRIEF.md
# Burst Address Counter with Readout

This block generates the internal address that one port of a dual-port memory uses for its accesses. Each rising clock edge applies one of five operations chosen by active-low strobes: clear the count to zero, take an external address, advance the count by one, keep the count while showing it on a readout bus, or keep the count and ignore the external address. The result is held in a register and driven out as the access address for the following cycle.

Clearing the counter costs no cycle. The address register reads zero in the cycle right after the clearing edge, so a memory access in that cycle uses address zero. The next edge can already advance or reload the count. A separate readout request drives the current count onto a registered output bus and raises its enable, without changing the count. The address width is a parameter and defaults to 15 bits.

Top module: `burst_addr_counter`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, the count, `addr_o`, `rd_bus_o` and `rd_oe_o` all become zero after that edge.
- R2: When `cnt_clr_n` is high and `adr_ld_n` is low at an edge, `addr_o` equals the `ext_addr_i` value sampled at that edge, whatever `cnt_step_n` and `rd_req_i` are.
- R3: When `cnt_clr_n` is low at an edge, `addr_o` becomes zero, whatever `adr_ld_n`, `cnt_step_n`, `rd_req_i` and `ext_addr_i` are. Clearing has the highest priority of the strobes.
- R4: A clear takes no dead cycle. `addr_o` reads zero in the very next cycle. An advance on the following edge gives 1, and a clear on consecutive edges keeps it at zero.
- R5: When `cnt_clr_n` and `adr_ld_n` are high, `rd_req_i` is low and `cnt_step_n` is low, `addr_o` increases by one on each edge.
- R6: Advancing from the all-ones count gives zero.
- R7: When `cnt_clr_n`, `adr_ld_n` and `cnt_step_n` are all high, `addr_o` keeps its value and any change on `ext_addr_i` has no effect.
- R8: When `rd_req_i` is high at an edge, `rd_oe_o` is high after that edge and `rd_bus_o` shows the count held before that edge. If no clear or load is also requested, the count does not change, even with `cnt_step_n` low. When `rd_req_i` is low, `rd_oe_o` and `rd_bus_o` are zero after the edge.
- R9: When both `adr_ld_n` and `cnt_step_n` are low and `cnt_clr_n` is high, the load wins over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr_i | input | AW | External address to load |
| adr_ld_n | input | 1 | Active-low address load strobe |
| cnt_step_n | input | 1 | Active-low count enable |
| cnt_clr_n | input | 1 | Active-low counter clear |
| rd_req_i | input | 1 | Readout request, active high |
| addr_o | output | AW | Registered internal access address |
| rd_bus_o | output | AW | Registered readout value of the count |
| rd_oe_o | output | 1 | Readout bus enable |

## Verification
The hardest situations to reach are those where several strobes are active on the same edge. Examples are a clear together with a load, an advance and a readout request, or a readout request while the count enable is low. Only the priority order decides the result in these cases. The stimulus table places such combinations right after counts that differ from zero, so a wrong winner shows up as a wrong address. The table also loads the all-ones value right before an advance, so the wrap is reached in two cycles instead of a full count sweep.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STEP  = 3'd3,
    OP_PEEK  = 3'd4
  } bac_op_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    step_n,
  input  logic    peek,
  output bac_op_e op
);
  // Priority: clear, load, readout (holds), step, hold
  always_comb begin
    if (!clr_n)       op = OP_CLEAR;
    else if (!ld_n)   op = OP_LOAD;
    else if (peek)    op = OP_PEEK;
    else if (!step_n) op = OP_STEP;
    else              op = OP_HOLD;
  end

  always_comb begin
    assert (!(op == OP_STEP && (!ld_n || !clr_n || peek)))
      else $error("AST_STEP_EXCLUSIVE failed"); // R9
  end
endmodule

// File: rtl/bac_count.sv
module bac_count
  import bac_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  bac_op_e       op,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] count
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext_addr;
      OP_STEP:  nxt = count + ONE;
      default:  nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end

  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP && count == '1) |=> count == '0); // R6
  AST_PEEK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PEEK) |=> $stable(count)); // R8
endmodule

// File: rtl/bac_readout.sv
module bac_readout #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] count,
  output logic [AW-1:0] bus,
  output logic          oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus <= '0;
      oe  <= 1'b0;
    end else begin
      oe  <= req;
      bus <= req ? count : '0;
    end
  end

  AST_READOUT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    req |=> (oe && bus == $past(count))); // R8
  AST_READOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!oe && bus == '0)); // R8
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr_i,
  input  logic          adr_ld_n,
  input  logic          cnt_step_n,
  input  logic          cnt_clr_n,
  input  logic          rd_req_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] rd_bus_o,
  output logic          rd_oe_o
);
  bac_op_e       op;
  logic [AW-1:0] count;

  bac_decode u_decode (
    .clr_n (cnt_clr_n),
    .ld_n  (adr_ld_n),
    .step_n(cnt_step_n),
    .peek  (rd_req_i),
    .op    (op)
  );

  bac_count #(.AW(AW)) u_count (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .ext_addr(ext_addr_i),
    .count   (count)
  );

  bac_readout #(.AW(AW)) u_readout (
    .clk  (clk),
    .rst  (rst),
    .req  (rd_req_i),
    .count(count),
    .bus  (rd_bus_o),
    .oe   (rd_oe_o)
  );

  assign addr_o = count;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && !rd_oe_o && rd_bus_o == '0)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && !adr_ld_n) |=> addr_o == $past(ext_addr_i)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr_n |=> addr_o == '0); // R3
  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && adr_ld_n && !rd_req_i && !cnt_step_n)
      |=> addr_o == $past(addr_o) + 1'b1); // R5
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && adr_ld_n && cnt_step_n) |=> $stable(addr_o)); // R7
endmodule

// File: tb/burst_addr_counter_bench.sv
module burst_addr_counter_bench;
  localparam int AW = 15;
  localparam int VW = 4 + AW + AW + 1 + AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr_i = '0;
  logic          adr_ld_n = 1'b1, cnt_step_n = 1'b1, cnt_clr_n = 1'b1, rd_req_i = 1'b0;
  logic [AW-1:0] addr_o, rd_bus_o;
  logic          rd_oe_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  burst_addr_counter #(.AW(AW)) u_burst_addr_counter (
    .clk(clk), .rst(rst), .ext_addr_i(ext_addr_i), .adr_ld_n(adr_ld_n),
    .cnt_step_n(cnt_step_n), .cnt_clr_n(cnt_clr_n), .rd_req_i(rd_req_i),
    .addr_o(addr_o), .rd_bus_o(rd_bus_o), .rd_oe_o(rd_oe_o)
  );

  function automatic logic [VW-1:0] mk(input logic clr_n, input logic ld_n,
      input logic st_n, input logic ro, input logic [AW-1:0] ext,
      input logic [AW-1:0] ea, input logic eoe, input logic [AW-1:0] eb);
    return {clr_n, ld_n, st_n, ro, ext, ea, eoe, eb};
  endfunction

  // fields: clr_n ld_n step_n readout ext | expected addr oe bus
  localparam logic [VW-1:0] VEC [15] = '{
    mk(1,0,1,0,15'h1234, 15'h1234,0,15'h0000), // R2 load
    mk(1,1,0,0,15'h0000, 15'h1235,0,15'h0000), // R5 step
    mk(1,1,0,0,15'h7777, 15'h1236,0,15'h0000), // R5 step, ext ignored
    mk(1,1,1,0,15'h7777, 15'h1236,0,15'h0000), // R7 hold
    mk(1,1,1,0,15'h0abc, 15'h1236,0,15'h0000), // R7 ext change ignored
    mk(1,1,0,1,15'h0000, 15'h1236,1,15'h1236), // R8 readout holds count
    mk(1,1,0,0,15'h0000, 15'h1237,0,15'h0000), // R8 readout released
    mk(1,0,0,0,15'h0100, 15'h0100,0,15'h0000), // R9 load beats step
    mk(0,0,0,0,15'h5555, 15'h0000,0,15'h0000), // R3 clear beats all
    mk(1,1,0,0,15'h5555, 15'h0001,0,15'h0000), // R4 step right after clear
    mk(1,0,1,0,15'h7fff, 15'h7fff,0,15'h0000), // R2 load all-ones
    mk(1,1,0,0,15'h0000, 15'h0000,0,15'h0000), // R6 wrap
    mk(1,0,1,0,15'h0042, 15'h0042,0,15'h0000), // R2 load
    mk(0,1,0,1,15'h0000, 15'h0000,1,15'h0042), // R3 clear with readout
    mk(1,1,0,0,15'h0000, 15'h0001,0,15'h0000)  // R4 step after clear
  };
  localparam int REQ [15] = '{2,5,5,7,7,8,8,9,3,4,2,6,2,3,4};

  task automatic check(input string tag, input logic [AW-1:0] ea,
                       input logic eoe, input logic [AW-1:0] eb);
    checks++;
    if (addr_o !== ea || rd_oe_o !== eoe || rd_bus_o !== eb) begin
      errors++;
      $display("FAIL %s: addr=%h oe=%b bus=%h expected addr=%h oe=%b bus=%h",
               tag, addr_o, rd_oe_o, rd_bus_o, ea, eoe, eb);
    end
  endtask

  task automatic drive(input logic cl, input logic ld, input logic st,
                       input logic ro, input logic [AW-1:0] ext);
    cnt_clr_n = cl; adr_ld_n = ld; cnt_step_n = st; rd_req_i = ro; ext_addr_i = ext;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", '0, 1'b0, '0);

    for (int i = 0; i < 15; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[VW-1], v[VW-2], v[VW-3], v[VW-4], v[VW-5 -: AW]);
      check($sformatf("R%0d vec %0d", REQ[i], i),
            v[AW+AW : AW+1], v[AW], v[AW-1:0]);
    end

    // R4: consecutive clears stay at zero, then stepping resumes
    drive(1, 0, 1, 0, 15'h3333);
    drive(0, 1, 0, 0, 15'h0000);
    check("R4 first clear", '0, 1'b0, '0);
    drive(0, 1, 0, 0, 15'h0000);
    check("R4 second clear", '0, 1'b0, '0);
    drive(1, 1, 0, 0, 15'h0000);
    drive(1, 1, 0, 0, 15'h0000);
    check("R4 two steps after clear", 15'h0002, 1'b0, '0);

    // R8: load during readout shows the older count, count takes the load
    drive(1, 0, 1, 1, 15'h0200);
    check("R8 readout with load", 15'h0200, 1'b1, 15'h0002);

    // R1: synchronous reset mid-run with readout pending
    drive(1, 1, 1, 1, 15'h0000);
    rst = 1'b1;
    drive(1, 0, 0, 1, 15'h1111);
    check("R1 reset mid-run", '0, 1'b0, '0);
    rst = 1'b0;
    drive(1, 1, 0, 0, 15'h0000);
    check("R1 run after reset", 15'h0001, 1'b0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule